// File: doc/BRIEF.md
# Coalescing Store Queue

This block is a short store queue placed between a write-through cache and a slower memory. The processor side offers one store per cycle. Each store carries a word address, a data word, per-byte enables and a flag that marks the target as a device (I/O) location. The memory side sees the oldest pending entry as a full block and takes it with a valid/ready handshake.

A normal store whose block already has a younger pending entry is folded into that entry, so repeated writes to one block cost a single memory transaction. The oldest entry is never a fold target, because the memory side may be sampling it. Device stores never fold, and nothing folds into them. A normal store also never folds into an entry that is older than a pending device store, so device accesses keep their place in program order. The processor is held off only when every slot is in use and the store can neither fold nor use a slot freed in the same cycle.

Top module: `merge_wbuf`

## Requirements
- R1: After a synchronous reset, `empty` is 1, `full` is 0, `count` is 0 and `out_valid` is 0.
- R2: Entries leave in allocation order. `out_*` always shows the oldest entry while `count` is nonzero, and that entry is removed on a rising edge where `out_valid` and `out_ready` are both 1.
- R3: The block number is `in_addr >> log2(BLK_WORDS)` and the lane is the low `log2(BLK_WORDS)` address bits. Lane k occupies `out_data[k*DATA_W +: DATA_W]`, and its byte j enable is `out_be[k*BYTES + j]`. Lanes and bytes never written read as 0 with enable 0.
- R4: A normal store to the block of a non-oldest, non-device entry updates that entry in place and leaves `count` unchanged. The enables are ORed in and only the enabled bytes are overwritten.
- R5: A store whose block matches only the oldest entry allocates a new slot. The oldest entry's outputs hold steady while it waits for `out_ready`.
- R6: A device store (`in_io`=1) always allocates its own slot, is shown with `out_io`=1, and no later store folds into it.
- R7: A normal store does not fold into an entry that is older than any pending device entry. It allocates instead.
- R8: `in_ready` is 0 only when the queue is full, the store cannot fold and no entry is leaving in that cycle.
- R9: When full, a store presented while the oldest entry leaves is accepted into the freed slot, and `count` stays at DEPTH.
- R10: `count` equals the number of pending entries (never above DEPTH). `full` is `count==DEPTH` and `empty` is `count==0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Store offered |
| in_ready | output | 1 | Store accepted this cycle |
| in_addr | input | ADDR_W | Word address of the store |
| in_data | input | DATA_W | Store data |
| in_be | input | DATA_W/8 | Byte enables of the store |
| in_io | input | 1 | Store targets a device location |
| out_valid | output | 1 | Oldest entry present |
| out_ready | input | 1 | Memory takes the oldest entry |
| out_blk | output | ADDR_W-log2(BLK_WORDS) | Block number of the oldest entry |
| out_data | output | BLK_WORDS*DATA_W | Block data, lane 0 in the low bits |
| out_be | output | BLK_WORDS*DATA_W/8 | Byte enables of the block |
| out_io | output | 1 | Oldest entry is a device store |
| full | output | 1 | All slots in use |
| empty | output | 1 | No slot in use |
| count | output | log2(DEPTH+1) | Pending entry count |

## Verification
The interesting collision is a store arriving in the same cycle that the oldest entry leaves. On a full queue this is provoked by raising `out_ready` together with `in_valid` for a store to a new block. Before the edge, `in_ready` must already be 1 and the leaving entry must be shown intact. Afterwards, `count` must remain at DEPTH, and the new store must come out last in the drain sequence. The second collision is a fold while full: a store to the block of a middle entry must be accepted without a pop, and its bytes must appear in that entry when it drains.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // position of a slot counted from the read pointer (0 = oldest)
  function automatic int unsigned slot_age(input int unsigned idx,
                                           input int unsigned rd,
                                           input int unsigned depth);
    return (idx + depth - rd) % depth;
  endfunction

  // next ring index with wrap at depth
  function automatic int unsigned ring_next(input int unsigned p,
                                            input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 14,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [CNT_W-1:0] cnt,
  input  logic [BLK_W-1:0] blk_q [DEPTH],
  input  logic             io_q  [DEPTH],
  input  logic [BLK_W-1:0] in_blk,
  input  logic             in_io,
  output logic             hit,
  output logic [PTR_W-1:0] hit_idx
);
  import wbuf_pkg::*;

  logic [CNT_W-1:0] age [DEPTH];
  logic             live [DEPTH];
  logic [CNT_W-1:0] youngest_io;
  logic             io_seen;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age[i]  = CNT_W'(slot_age(i, rd_ptr, DEPTH));
      live[i] = age[i] < cnt;
    end
  end

  // age of the newest pending device entry
  always_comb begin
    io_seen     = 1'b0;
    youngest_io = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && io_q[i] && (!io_seen || age[i] > youngest_io)) begin
        io_seen     = 1'b1;
        youngest_io = age[i];
      end
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && !io_q[i] && !in_io && age[i] != '0 &&
          blk_q[i] == in_blk && (!io_seen || age[i] > youngest_io)) begin
        hit     = 1'b1;
        hit_idx = PTR_W'(i);
      end
    end
  end

  p_hit_not_io_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> (!in_io && !io_q[hit_idx]));
endmodule

// File: rtl/wbuf_entries.sv
module wbuf_entries #(
  parameter int DEPTH     = 4,
  parameter int BLK_W     = 14,
  parameter int BLK_WORDS = 4,
  parameter int DATA_W    = 32,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LANE_W = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
  localparam int BYTES  = DATA_W / 8,
  localparam int LINE_W = BLK_WORDS * DATA_W,
  localparam int LBE_W  = BLK_WORDS * BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_alloc,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BYTES-1:0]  wr_be,
  input  logic              wr_io,
  output logic [BLK_W-1:0]  blk_q  [DEPTH],
  output logic              io_q   [DEPTH],
  output logic [LINE_W-1:0] data_q [DEPTH],
  output logic [LBE_W-1:0]  be_q   [DEPTH]
);
  function automatic logic [LBE_W-1:0] lane_mask(input logic [LANE_W-1:0] ln,
                                                 input logic [BYTES-1:0] be);
    logic [LBE_W-1:0] r;
    r = '0;
    r[ln*BYTES +: BYTES] = be;
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] lane_word(input logic [LANE_W-1:0] ln,
                                                  input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = '0;
    r[ln*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] bit_mask(input logic [LBE_W-1:0] m);
    logic [LINE_W-1:0] r;
    for (int b = 0; b < LBE_W; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  logic [LBE_W-1:0]  new_mask;
  logic [LINE_W-1:0] new_word;
  logic [LINE_W-1:0] new_bits;

  assign new_mask = lane_mask(wr_lane, wr_be);
  assign new_word = lane_word(wr_lane, wr_data);
  assign new_bits = bit_mask(new_mask);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [LINE_W-1:0] base_data;
    logic [LBE_W-1:0]  base_be;
    // an allocation starts from an empty slot, a fold from its contents
    assign base_data = wr_alloc ? '0 : data_q[e];
    assign base_be   = wr_alloc ? '0 : be_q[e];

    always_ff @(posedge clk) begin
      if (rst) begin
        blk_q[e]  <= '0;
        io_q[e]   <= 1'b0;
        data_q[e] <= '0;
        be_q[e]   <= '0;
      end else if (wr_en && wr_idx == PTR_W'(e)) begin
        if (wr_alloc) begin
          blk_q[e] <= wr_blk;
          io_q[e]  <= wr_io;
        end
        be_q[e]   <= base_be | new_mask;
        data_q[e] <= (base_data & ~new_bits) | (new_word & new_bits);
      end
    end
  end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int DEPTH     = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int BLK_WORDS = 4,
  localparam int OFS_W  = $clog2(BLK_WORDS),
  localparam int BLK_W  = ADDR_W - OFS_W,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int BYTES  = DATA_W / 8,
  localparam int LINE_W = BLK_WORDS * DATA_W,
  localparam int LBE_W  = BLK_WORDS * BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BYTES-1:0]  in_be,
  input  logic              in_io,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_blk,
  output logic [LINE_W-1:0] out_data,
  output logic [LBE_W-1:0]  out_be,
  output logic              out_io,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  import wbuf_pkg::*;

  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] lane_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic [BLK_W-1:0]  blk_q  [DEPTH];
  logic              io_q   [DEPTH];
  logic [LINE_W-1:0] data_q [DEPTH];
  logic [LBE_W-1:0]  be_q   [DEPTH];

  // named events for the assertions
  logic             merge_hit;
  logic [PTR_W-1:0] merge_idx;
  logic             push_fire, pop_fire, alloc;

  wbuf_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_match (
    .clk(clk), .rst(rst), .rd_ptr(rd_ptr), .cnt(cnt_q),
    .blk_q(blk_q), .io_q(io_q),
    .in_blk(blk_of(in_addr)), .in_io(in_io),
    .hit(merge_hit), .hit_idx(merge_idx)
  );

  assign full      = cnt_q == CNT_W'(DEPTH);
  assign empty     = cnt_q == '0;
  assign count     = cnt_q;
  assign out_valid = !empty;
  assign pop_fire  = out_valid && out_ready;
  assign in_ready  = !full || merge_hit || pop_fire;
  assign push_fire = in_valid && in_ready;
  assign alloc     = push_fire && !merge_hit;

  wbuf_entries #(.DEPTH(DEPTH), .BLK_W(BLK_W), .BLK_WORDS(BLK_WORDS),
                 .DATA_W(DATA_W)) u_entries (
    .clk(clk), .rst(rst),
    .wr_en(push_fire), .wr_alloc(alloc),
    .wr_idx(merge_hit ? merge_idx : wr_ptr),
    .wr_blk(blk_of(in_addr)), .wr_lane(lane_of(in_addr)),
    .wr_data(in_data), .wr_be(in_be), .wr_io(in_io),
    .blk_q(blk_q), .io_q(io_q), .data_q(data_q), .be_q(be_q)
  );

  assign out_blk  = blk_q[rd_ptr];
  assign out_data = data_q[rd_ptr];
  assign out_be   = be_q[rd_ptr];
  assign out_io   = io_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_fire) rd_ptr <= PTR_W'(ring_next(rd_ptr, DEPTH));
      if (alloc)    wr_ptr <= PTR_W'(ring_next(wr_ptr, DEPTH));
      case ({alloc, pop_fire})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (empty && !full && !out_valid));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_head_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      ($stable(out_data) && $stable(out_be) && $stable(out_blk) && $stable(out_io)));

  p_merge_not_head_r5: assert property (@(posedge clk) disable iff (rst)
    (push_fire && merge_hit) |-> (merge_idx != rd_ptr));

  p_merge_keeps_count_r4: assert property (@(posedge clk) disable iff (rst)
    (push_fire && merge_hit && !pop_fire) |=> $stable(count));

  p_io_allocates_r6: assert property (@(posedge clk) disable iff (rst)
    (push_fire && in_io) |-> alloc);

  p_stall_only_full_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |-> (full && !merge_hit && !out_ready));

  p_full_swap_r9: assert property (@(posedge clk) disable iff (rst)
    (full && pop_fire && alloc) |=> full);
endmodule

// File: tb/merge_wbuf_bench.sv
module merge_wbuf_bench;
  localparam int LINE_W = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [15:0]  in_addr = '0;
  logic [31:0]  in_data = '0;
  logic [3:0]   in_be = '0;
  logic         in_io = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [13:0]  out_blk;
  logic [127:0] out_data;
  logic [15:0]  out_be;
  logic         out_io;
  logic         full, empty;
  logic [2:0]   count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  merge_wbuf u_merge_wbuf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .in_be(in_be), .in_io(in_io),
    .out_valid(out_valid), .out_ready(out_ready), .out_blk(out_blk),
    .out_data(out_data), .out_be(out_be), .out_io(out_io),
    .full(full), .empty(empty), .count(count)
  );

  task automatic chk(input string req, input logic [LINE_W-1:0] act,
                     input logic [LINE_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // store accepted in one cycle; in_ready is sampled before the edge
  task automatic push(input logic [15:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic io, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d; in_be = be; in_io = io;
    #1 chk({req, " in_ready"}, in_ready, 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // take the oldest entry and compare its contents
  task automatic pop(input logic [13:0] blk, input logic [127:0] d,
                     input logic [15:0] be, input logic io, input string req);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk({req, " out_valid"}, out_valid, 1);
    chk({req, " out_blk"}, out_blk, blk);
    chk({req, " out_data"}, out_data, d);
    chk({req, " out_be"}, out_be, be);
    chk({req, " out_io"}, out_io, io);
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic chk_count(input int n, input string req);
    @(negedge clk);
    chk({req, " count"}, count, n);
    chk({req, " full"}, full, n == 4);
    chk({req, " empty"}, empty, n == 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 count", count, 0);
    chk("R1 out_valid", out_valid, 0);
  endtask

  // R3 R4 R5: folding into a younger entry, the oldest is skipped
  task automatic t_merge;
    push(16'd4,  32'hDEADBEEF, 4'hF, 0, "R5");
    push(16'd20, 32'h11223344, 4'hF, 0, "R4");
    push(16'd22, 32'h55667788, 4'h3, 0, "R4");
    push(16'd20, 32'hAABBCCDD, 4'h2, 0, "R4");
    chk_count(2, "R4 after folds");
    push(16'd5,  32'h01020304, 4'hF, 0, "R5");
    chk_count(3, "R5 head excluded");
    // R5: head stays steady while held off
    @(negedge clk);
    chk("R5 head held", out_data, 128'hDEADBEEF);
    pop(14'd1, 128'hDEADBEEF, 16'h000F, 0, "R2 R3");
    pop(14'd5, 128'h00000000_00007788_00000000_1122CC44, 16'h030F, 0, "R4 R3");
    pop(14'd1, 128'h00000000_00000000_01020304_00000000, 16'h00F0, 0, "R2 R5");
    chk_count(0, "R10 drained");
  endtask

  // R6: device stores stay separate; normal stores fold only after them
  task automatic t_io;
    push(16'd40, 32'hA0A0A0A0, 4'hF, 1, "R6");
    push(16'd40, 32'hB0B0B0B0, 4'hF, 1, "R6");
    push(16'd41, 32'hC1C1C1C1, 4'hF, 0, "R6");
    chk_count(3, "R6 device not a target");
    push(16'd42, 32'hC2C2C2C2, 4'h3, 0, "R6");
    chk_count(3, "R6 fold after device");
    pop(14'd10, 128'hA0A0A0A0, 16'h000F, 1, "R6 first");
    pop(14'd10, 128'hB0B0B0B0, 16'h000F, 1, "R6 second");
    pop(14'd10, 128'h00000000_0000C2C2_C1C1C1C1_00000000, 16'h03F0, 0, "R6 normal");
    chk_count(0, "R10 drained");
  endtask

  // R7: no fold into an entry older than a pending device store
  task automatic t_order;
    push(16'd100, 32'h1, 4'hF, 0, "R7");
    push(16'd80,  32'h2, 4'hF, 0, "R7");
    push(16'd200, 32'h3, 4'hF, 1, "R7");
    push(16'd81,  32'h4, 4'hF, 0, "R7");
    chk_count(4, "R7 no fold across device");
    pop(14'd25, 128'h1, 16'h000F, 0, "R7 a");
    pop(14'd20, 128'h2, 16'h000F, 0, "R7 b");
    pop(14'd50, 128'h3, 16'h000F, 1, "R7 c");
    pop(14'd20, 128'h4 << 32, 16'h00F0, 0, "R7 d");
    chk_count(0, "R10 drained");
  endtask

  // R8 R9: stall, fold while full, and a push meeting a pop
  task automatic t_full;
    push(16'd0,  32'h10, 4'hF, 0, "R8");
    push(16'd4,  32'h11, 4'hF, 0, "R8");
    push(16'd8,  32'h12, 4'hF, 0, "R8");
    push(16'd12, 32'h13, 4'hF, 0, "R8");
    chk_count(4, "R10 full");
    @(negedge clk);
    in_valid = 1'b1; in_addr = 16'd16; in_data = 32'h14; in_be = 4'hF; in_io = 1'b0;
    #1 chk("R8 stall when full", in_ready, 0);
    @(posedge clk);
    #1 in_valid = 1'b0;
    chk_count(4, "R8 stalled store dropped");
    push(16'd9, 32'h22, 4'hF, 0, "R8 fold while full");
    chk_count(4, "R8 fold keeps count");
    @(negedge clk);
    in_valid = 1'b1; in_addr = 16'd16; in_data = 32'h14; in_be = 4'hF; in_io = 1'b0;
    out_ready = 1'b1;
    #1;
    chk("R9 in_ready with pop", in_ready, 1);
    chk("R9 leaving blk", out_blk, 0);
    chk("R9 leaving data", out_data, 128'h10);
    @(posedge clk);
    #1 in_valid = 1'b0; out_ready = 1'b0;
    chk_count(4, "R9 count held");
    pop(14'd1, 128'h11, 16'h000F, 0, "R2 a");
    pop(14'd2, 128'h22_00000012, 16'h00FF, 0, "R8 folded");
    pop(14'd3, 128'h13, 16'h000F, 0, "R2 c");
    pop(14'd4, 128'h14, 16'h000F, 0, "R9 new last");
    chk_count(0, "R10 drained");
  endtask

  initial begin
    t_reset();
    t_merge();
    t_io();
    t_order();
    t_full();
    // R1: reset while holding entries empties the queue
    push(16'd60, 32'h5, 4'hF, 0, "R1");
    t_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule